// File: doc/BRIEF.md
# Delay-line oscillator phase quantizer

This block turns the frequency of two oscillator channels into a multi-bit, first-order noise-shaped digital stream. Each channel's oscillator signal is divided by four and sent out to a 31-tap delay line. The tap vector of that line comes back in, is resynchronized to the system clock (nominally 20 MHz for a 20 kHz audio band) and is compared with the sample taken one clock earlier. Each tap whose value changed marks a sub-clock edge position. The number of changed taps is the channel word (0 to 31). The differential output is channel A minus channel B in two's complement.

The taps act like a sampler running far faster than the system clock. The block therefore resolves fractions of a clock period instead of counting only whole edges. The result leaves on a valid/ready stream. The sampler cannot stall. While the output word is offered and not taken, it holds still. Fresh samples that arrive during that time are discarded. The first word after ready returns is the newest difference.

Top module: `osc_phase_quantizer`

## Requirements
- R1: Each channel's divided output `div_*_o` is 0 after reset and changes on every second rising edge of that channel's oscillator input, giving one quarter of its frequency. The two channels are independent.
- R2: Tap vectors pass through two synchronizer stages. The word that appears after clock edge m is built from the tap vectors present at edges m-2 and m-3.
- R3: The first-order difference marks tap i when its value differs between the two samples (bitwise XOR of current and previous). The channel word is the number of marked taps, 0 to 31.
- R4: The channel word counts marked taps wherever they lie, so non-contiguous patterns (bubbles) are counted exactly.
- R5: `out_data_o` is the channel A word minus the channel B word as a 6-bit two's-complement value, from -31 to +31.
- R6: After reset release `out_valid_o` and `out_data_o` stay 0 until the 4th rising clock edge, the first at which a full pair of post-reset samples exists. From that edge on `out_valid_o` is 1.
- R7: Once valid, `out_valid_o` stays 1 and, while `out_ready_i` is 1, a new word is loaded on every clock edge.
- R8: While `out_valid_o` is 1 and `out_ready_i` is 0 at a clock edge, `out_data_o` keeps its value and the new sample is discarded. At the first edge with `out_ready_i` at 1 the current difference is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_a_i | input | 1 | Channel A oscillator signal |
| osc_b_i | input | 1 | Channel B oscillator signal |
| div_a_o | output | 1 | Channel A oscillator divided by four, to the delay line |
| div_b_o | output | 1 | Channel B oscillator divided by four, to the delay line |
| tap_a_i | input | 31 | Channel A delay-line tap vector |
| tap_b_i | input | 31 | Channel B delay-line tap vector |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream accepts the word |
| out_data_o | output | 6 | Differential word, two's complement |

## Verification
The assertions check four rules on every cycle. The word is held stable under back-pressure. The output is zero while not yet valid. Valid never drops once it has risen. The differential value stays within plus or minus 31. In the divider, no two successive oscillator edges both change the divided output. Only the bench scenarios can show the following: the exact counts for thermometer and bubble patterns, the three-edge alignment between a tap change and its word, the sign at both extremes, and which fresh sample follows a back-pressure stall.

// File: rtl/opq_pkg.sv
package opq_pkg;
  localparam int unsigned DEF_TAPS     = 31;
  localparam int unsigned DEF_SYNC     = 2;
  localparam int unsigned DEF_DIV_LOG2 = 2;
endpackage

// File: rtl/opq_osc_div.sv
module opq_osc_div #(
  parameter int unsigned DIV_LOG2 = opq_pkg::DEF_DIV_LOG2
) (
  input  logic osc_i,
  input  logic rst_n,
  output logic div_o
);
  logic [DIV_LOG2-1:0] cnt;

  always_ff @(posedge osc_i or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign div_o = cnt[DIV_LOG2-1];

  // R1: a change of the divided signal is never followed by another on the next edge
  assert_div_no_double_toggle_R1: assert property (@(posedge osc_i) disable iff (!rst_n)
    $changed(div_o) |=> $stable(div_o));
endmodule

// File: rtl/opq_tap_sync.sv
module opq_tap_sync #(
  parameter int unsigned W      = opq_pkg::DEF_TAPS,
  parameter int unsigned STAGES = opq_pkg::DEF_SYNC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tap_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      prev_q <= '0;
    end else begin
      stg[0] <= tap_i;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      prev_q <= stg[STAGES-1];
    end
  end

  assign cur_o  = stg[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/opq_therm2bin.sv
module opq_therm2bin #(
  parameter int unsigned W  = opq_pkg::DEF_TAPS,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits_i,
  output logic [CW-1:0] count_o
);
  always_comb begin
    count_o = '0;
    for (int i = 0; i < W; i++) count_o = count_o + CW'(bits_i[i]);
  end
endmodule

// File: rtl/osc_phase_quantizer.sv
module osc_phase_quantizer #(
  parameter int unsigned TAPS        = opq_pkg::DEF_TAPS,
  parameter int unsigned SYNC_STAGES = opq_pkg::DEF_SYNC,
  parameter int unsigned DIV_LOG2    = opq_pkg::DEF_DIV_LOG2,
  localparam int unsigned CNT_W      = $clog2(TAPS + 1),
  localparam int unsigned OUT_W      = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_a_i,
  input  logic             osc_b_i,
  output logic             div_a_o,
  output logic             div_b_o,
  input  logic [TAPS-1:0]  tap_a_i,
  input  logic [TAPS-1:0]  tap_b_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [OUT_W-1:0] out_data_o
);
  localparam int unsigned FILL   = SYNC_STAGES + 1;
  localparam int unsigned FILL_W = $clog2(FILL + 1);

  logic              osc_in  [2];
  logic              div_w   [2];
  logic [TAPS-1:0]   tap_in  [2];
  logic [CNT_W-1:0]  ch_cnt  [2];

  assign osc_in[0] = osc_a_i;
  assign osc_in[1] = osc_b_i;
  assign tap_in[0] = tap_a_i;
  assign tap_in[1] = tap_b_i;
  assign div_a_o   = div_w[0];
  assign div_b_o   = div_w[1];

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic [TAPS-1:0] cur, prev;

    opq_osc_div #(.DIV_LOG2(DIV_LOG2)) u_div (
      .osc_i(osc_in[ch]), .rst_n(rst_n), .div_o(div_w[ch]));

    opq_tap_sync #(.W(TAPS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .tap_i(tap_in[ch]), .cur_o(cur), .prev_o(prev));

    opq_therm2bin #(.W(TAPS), .CW(CNT_W)) u_t2b (
      .bits_i(cur ^ prev), .count_o(ch_cnt[ch]));
  end

  logic [FILL_W-1:0] fill;
  logic              pair_ok;
  logic [OUT_W-1:0]  word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       fill <= '0;
    else if (fill != FILL_W'(FILL))   fill <= fill + 1'b1;
  end

  assign pair_ok = (fill == FILL_W'(FILL));
  assign word    = {1'b0, ch_cnt[0]} - {1'b0, ch_cnt[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else if (!out_valid_o || out_ready_i) begin
      out_valid_o <= pair_ok;
      out_data_o  <= pair_ok ? word : '0;
    end
  end

  // R8: a word not taken stays put
  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
  // R6: nothing but zero before the first valid word
  assert_zero_before_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid_o |-> (out_data_o == '0));
  // R7: valid never drops once raised
  assert_valid_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |=> out_valid_o);
  // R5: differential word within the tap count
  assert_word_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(out_data_o) <= $signed(TAPS)) && ($signed(out_data_o) >= -$signed(TAPS)));
endmodule

// File: tb/osc_phase_quantizer_tb.sv
module osc_phase_quantizer_tb;
  localparam int TAPS = 31;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_a = 1'b0, osc_b = 1'b0;
  logic div_a, div_b;
  logic [TAPS-1:0] tap_a = '0, tap_b = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [5:0] out_data;

  int total = 0, bad = 0;
  bit done = 0;
  string phase = "R2";

  int tag_q[$];
  int exp_q[$];
  int drv_m = 0;
  logic [TAPS-1:0] pa = '0, pb = '0;
  int edge_n = 0;
  bit strict = 0;
  logic last_v = 1'b0;
  logic [5:0] last_d = '0;

  always #2 clk = ~clk;

  osc_phase_quantizer u_dut (
    .clk(clk), .rst_n(rst_n), .osc_a_i(osc_a), .osc_b_i(osc_b),
    .div_a_o(div_a), .div_b_o(div_b), .tap_a_i(tap_a), .tap_b_i(tap_b),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data));

  function automatic int popcnt(input logic [TAPS-1:0] v);
    int n = 0;
    for (int i = 0; i < TAPS; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0d expected=%0d (edge %0d)", req, got, exp, edge_n);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tap_a = '0; tap_b = '0; out_ready = 1'b1;
    tag_q.delete(); exp_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1; drv_m = 1; pa = '0; pb = '0;
  endtask

  task automatic drive(input logic [TAPS-1:0] a, input logic [TAPS-1:0] b, input bit rdy);
    @(negedge clk);
    tap_a = a; tap_b = b; out_ready = rdy; drv_m++;
    tag_q.push_back(drv_m + 2);
    exp_q.push_back(popcnt(a ^ pa) - popcnt(b ^ pb));
    pa = a; pb = b;
  endtask

  task automatic osc_pulse(input bit ch);
    if (ch) osc_b = 1'b1; else osc_a = 1'b1;
    #3;
    if (ch) osc_b = 1'b0; else osc_a = 1'b0;
    #3;
  endtask

  // monitor: samples 1 ns after each rising edge
  initial forever begin
    @(posedge clk); #1;
    if (!rst_n) begin
      edge_n = 0; last_v = 1'b0; last_d = '0;
    end else begin
      edge_n++;
      if (edge_n < 4) begin
        chk(out_valid == 1'b0 && out_data == '0, "R6", int'(out_valid), 0);
      end else begin
        chk(out_valid == 1'b1, "R7", int'(out_valid), 1);
        if (out_ready || !last_v) begin
          while (tag_q.size() > 0 && tag_q[0] < edge_n) begin
            void'(tag_q.pop_front()); void'(exp_q.pop_front());
          end
          if (tag_q.size() > 0 && tag_q[0] == edge_n) begin
            chk(int'($signed(out_data)) == exp_q[0], phase, int'($signed(out_data)), exp_q[0]);
            void'(tag_q.pop_front()); void'(exp_q.pop_front());
          end else if (strict) begin
            chk(1'b0, "R2", -1, edge_n);
          end
        end else begin
          chk(out_data == last_d, "R8", int'($signed(out_data)), int'($signed(last_d)));
        end
      end
      last_v = out_valid; last_d = out_data;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog got=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && out_data == '0, "R6", int'(out_data), 0);
    chk(div_a == 1'b0 && div_b == 1'b0, "R1", int'(div_a), 0);
    do_reset();

    // R1: divide by four, channels independent
    osc_pulse(0);
    chk(div_a == 1'b0, "R1", int'(div_a), 0);
    osc_pulse(0);
    chk(div_a == 1'b1, "R1", int'(div_a), 1);
    chk(div_b == 1'b0, "R1", int'(div_b), 0);
    osc_pulse(0); osc_pulse(0);
    chk(div_a == 1'b0, "R1", int'(div_a), 0);
    osc_pulse(1); osc_pulse(1);
    chk(div_b == 1'b1, "R1", int'(div_b), 1);

    do_reset();
    strict = 1;
    // R2: single isolated change, alignment by tag
    phase = "R2";
    repeat (4) drive('0, '0, 1'b1);
    drive('1, '0, 1'b1);
    repeat (3) drive('1, '0, 1'b1);

    // R3: thermometer codes of varying depth
    phase = "R3";
    for (int i = 0; i < 40; i++) begin
      int ka = (i * 7) % 32;
      int kb = (i * 11 + 3) % 32;
      logic [TAPS-1:0] va = (ka == 0) ? '0 : ({TAPS{1'b1}} >> (TAPS - ka));
      logic [TAPS-1:0] vb = (kb == 0) ? '0 : ({TAPS{1'b1}} >> (TAPS - kb));
      drive(va, vb, 1'b1);
    end

    // R4: bubbles
    phase = "R4";
    for (int i = 0; i < 60; i++) drive(TAPS'($urandom), TAPS'($urandom), 1'b1);
    drive(31'h5555_5555, 31'h0F0F_0F0F, 1'b1);
    drive(31'h2AAA_AAAA, 31'h700F_0F0F, 1'b1);

    // R5: extremes and balance
    phase = "R5";
    for (int i = 0; i < 6; i++) drive((i % 2) ? '1 : '0, '0, 1'b1);
    for (int i = 0; i < 6; i++) drive('0, (i % 2) ? '0 : '1, 1'b1);
    for (int i = 0; i < 4; i++) drive((i % 2) ? '1 : '0, (i % 2) ? '1 : '0, 1'b1);

    // R8: back-pressure holds, then fresh sample
    phase = "R8";
    for (int i = 0; i < 5; i++) drive(TAPS'($urandom), TAPS'($urandom), 1'b0);
    for (int i = 0; i < 8; i++) drive(TAPS'($urandom), TAPS'($urandom), 1'b1);

    // R6: restart after a second reset
    phase = "R6";
    do_reset();
    for (int i = 0; i < 10; i++) drive(TAPS'($urandom), TAPS'($urandom), 1'b1);

    strict = 0;
    repeat (5) @(negedge clk);
    chk(tag_q.size() == 0, "R2", tag_q.size(), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule